// File: doc/BRIEF.md
# Spin-Lock Acquirer with Geometric Retry Delay

This block acquires a shared lock word on behalf of one processor. When the processor raises its acquire request, the block sends an atomic test-and-set command through a single-outstanding memory request/response port. If the old value is zero, the lock was free and is now owned, so the grant output rises. If the old value is non-zero, the block waits before it tries again. The first wait lasts a base number of cycles. Each further failure multiplies the wait by a power-of-two factor, up to a ceiling.

An optional read-spin mode puts a polling phase in front of every atomic attempt. The block issues plain reads of the lock word and sends the test-and-set only once a read returns zero. This keeps atomic traffic off the interconnect while another owner is inside its critical section. Release is a plain store of zero. A release request while the lock is not owned does nothing except pulse an error output for one cycle.

The `tts_mode` input is expected to stay constant while an acquisition is in progress.

Top module: `lkbo_spin_acquirer`

## Requirements
- R1: After reset `grant`, `mem_req_valid` and `rel_err` are 0.
- R2: When the response to a test-and-set (command code 1) carries data 0, `grant` is 1 from the cycle after the response and stays 1 until a release.
- R3: After the first failed test-and-set (non-zero response data), the next request appears exactly `BASE_DELAY` cycles after the response cycle, and never sooner.
- R4: Each further consecutive failure multiplies the wait by 2^`GROWTH_SHIFT`, and the wait saturates at `MAX_DELAY`.
- R5: With `tts_mode` = 1 the block issues reads (command code 0) and issues a test-and-set only on the cycle after a read returns 0. While reads return non-zero, it issues no test-and-set.
- R6: A release request while `grant` = 1 issues one write (command code 2) on the next cycle, and `grant` falls in that same cycle. The memory stores zero.
- R7: A release request while `grant` = 0 issues no memory request and leaves `grant` unchanged. It raises `rel_err` for exactly the following cycle.
- R8: `mem_req_valid` is a one-cycle pulse, and no new request is issued until the previous one has had its response.
- R9: The retry wait returns to `BASE_DELAY` after every successful acquisition.
- R10: With `tts_mode` = 0 the block never issues a read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tts_mode | input | 1 | 1 = poll with reads before each atomic attempt |
| acq_req | input | 1 | Acquire request, sampled while idle |
| rel_req | input | 1 | One-cycle release request |
| grant | output | 1 | Lock is owned by this requester |
| rel_err | output | 1 | One-cycle pulse on a release while not owned |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_cmd | output | 2 | 0 read, 1 test-and-set, 2 write zero |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_data | input | DATA_W | Old lock word value returned by the memory |

## Verification
The bound checker enforces the following on every cycle:
- at most one outstanding request;
- grant rising only after a zero test-and-set response;
- no retry sooner than the base delay after a failure;
- test-and-set in read-spin mode only after a zero read;
- the write that follows a release;
- an error pulse only for an unowned release.

Only the bench scenarios can show two things. The first is the exact delay sequence, with its geometric growth, its saturation and its return to the base after a successful acquisition. The second is that a spin against a held lock issues no atomic command. The bench does this by recording the request times against a behavioural memory.

// File: rtl/lkbo_pkg.sv
package lkbo_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_TAS   = 2'd1,
    CMD_WRITE = 2'd2
  } lk_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TAS,
    ST_BACK,
    ST_HELD,
    ST_WR
  } lk_state_e;
endpackage

// File: rtl/lkbo_delay_reg.sv
module lkbo_delay_reg #(
  parameter int BASE_DELAY   = 4,
  parameter int GROWTH_SHIFT = 1,
  parameter int MAX_DELAY    = 64,
  parameter int W            = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         grow,
  output logic [W-1:0] delay_o
);
  localparam int LIMIT = MAX_DELAY >> GROWTH_SHIFT;

  logic [W-1:0] dly_q;
  logic [W-1:0] dly_next;

  generate
    if (GROWTH_SHIFT == 0) begin : g_const
      assign dly_next = dly_q;
    end else begin : g_geom
      always_comb begin
        if (dly_q > W'(LIMIT)) dly_next = W'(MAX_DELAY);
        else                   dly_next = dly_q << GROWTH_SHIFT;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || restart) dly_q <= W'(BASE_DELAY);
    else if (grow)      dly_q <= dly_next;
  end

  assign delay_o = dly_q;
endmodule

// File: rtl/lkbo_wait_timer.sv
module lkbo_wait_timer #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign done = (cnt_q == W'(1));
endmodule

// File: rtl/lkbo_spin_acquirer.sv
module lkbo_spin_acquirer #(
  parameter int DATA_W       = 8,
  parameter int BASE_DELAY   = 4,
  parameter int GROWTH_SHIFT = 1,
  parameter int MAX_DELAY    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tts_mode,
  input  logic              acq_req,
  input  logic              rel_req,
  output logic              grant,
  output logic              rel_err,
  output logic              mem_req_valid,
  output logic [1:0]        mem_req_cmd,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  import lkbo_pkg::*;

  localparam int DLY_W = $clog2(MAX_DELAY + 1);

  lk_state_e        state_q;
  logic [DLY_W-1:0] cur_delay;
  logic             tas_ok, tas_fail, wait_done, lock_free;

  assign lock_free = (mem_rsp_data == '0);
  assign tas_ok    = (state_q == ST_TAS) && mem_rsp_valid && lock_free;
  assign tas_fail  = (state_q == ST_TAS) && mem_rsp_valid && !lock_free;

  lkbo_delay_reg #(
    .BASE_DELAY(BASE_DELAY), .GROWTH_SHIFT(GROWTH_SHIFT),
    .MAX_DELAY(MAX_DELAY), .W(DLY_W)
  ) i_delay (
    .clk(clk), .rst(rst), .restart(tas_ok), .grow(tas_fail), .delay_o(cur_delay)
  );

  lkbo_wait_timer #(.W(DLY_W)) i_timer (
    .clk(clk), .rst(rst), .load(tas_fail), .load_val(cur_delay), .done(wait_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      grant         <= 1'b0;
      rel_err       <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_cmd   <= CMD_READ;
    end else begin
      mem_req_valid <= 1'b0;
      rel_err       <= rel_req && (state_q != ST_HELD);
      case (state_q)
        ST_IDLE: if (acq_req) begin
          mem_req_valid <= 1'b1;
          mem_req_cmd   <= tts_mode ? CMD_READ : CMD_TAS;
          state_q       <= tts_mode ? ST_RD : ST_TAS;
        end
        ST_RD: if (mem_rsp_valid) begin
          mem_req_valid <= 1'b1;
          mem_req_cmd   <= lock_free ? CMD_TAS : CMD_READ;
          if (lock_free) state_q <= ST_TAS;
        end
        ST_TAS: if (mem_rsp_valid) begin
          if (lock_free) begin
            grant   <= 1'b1;
            state_q <= ST_HELD;
          end else begin
            state_q <= ST_BACK;
          end
        end
        ST_BACK: if (wait_done) begin
          mem_req_valid <= 1'b1;
          mem_req_cmd   <= tts_mode ? CMD_READ : CMD_TAS;
          state_q       <= tts_mode ? ST_RD : ST_TAS;
        end
        ST_HELD: if (rel_req) begin
          grant         <= 1'b0;
          mem_req_valid <= 1'b1;
          mem_req_cmd   <= CMD_WRITE;
          state_q       <= ST_WR;
        end
        ST_WR: if (mem_rsp_valid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lkbo_checker.sv
module lkbo_checker #(
  parameter int DATA_W     = 8,
  parameter int BASE_DELAY = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tts_mode,
  input logic              rel_req,
  input logic              grant,
  input logic              rel_err,
  input logic              mem_req_valid,
  input logic [1:0]        mem_req_cmd,
  input logic              mem_rsp_valid,
  input logic [DATA_W-1:0] mem_rsp_data
);
  localparam int CW = $clog2(BASE_DELAY + 1) + 1;

  logic          outstanding_q, rd_zero_q, armed_q;
  logic [1:0]    last_cmd_q, cur_cmd;
  logic [CW-1:0] since_q;

  assign cur_cmd = mem_req_valid ? mem_req_cmd : last_cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding_q <= 1'b0;
      rd_zero_q     <= 1'b0;
      armed_q       <= 1'b0;
      last_cmd_q    <= 2'd0;
      since_q       <= '0;
    end else begin
      outstanding_q <= (outstanding_q || mem_req_valid) && !mem_rsp_valid;
      if (mem_req_valid) last_cmd_q <= mem_req_cmd;
      if (mem_rsp_valid) rd_zero_q <= (cur_cmd == 2'd0) && (mem_rsp_data == '0);
      if (mem_rsp_valid && cur_cmd == 2'd1 && mem_rsp_data != '0) begin
        armed_q <= 1'b1;
        since_q <= '0;
      end else begin
        if (mem_req_valid) armed_q <= 1'b0;
        if (since_q < CW'(BASE_DELAY)) since_q <= since_q + CW'(1);
      end
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !outstanding_q); // R8
  AST_GRANT_ON_FREE: assert property (@(posedge clk) disable iff (rst)
    $rose(grant) |-> $past(mem_rsp_valid && cur_cmd == 2'd1 && mem_rsp_data == '0)); // R2
  AST_BACKOFF_MIN: assert property (@(posedge clk) disable iff (rst)
    (armed_q && mem_req_valid) |-> (since_q >= CW'(BASE_DELAY))); // R3
  AST_SPIN_BEFORE_TAS: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_cmd == 2'd1 && tts_mode) |-> rd_zero_q); // R5
  AST_RELEASE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rel_req && grant) |=> (mem_req_valid && mem_req_cmd == 2'd2 && !grant)); // R6
  AST_ERR_UNHELD: assert property (@(posedge clk) disable iff (rst)
    rel_err |-> $past(rel_req && !grant)); // R7
endmodule

bind lkbo_spin_acquirer lkbo_checker #(.DATA_W(DATA_W), .BASE_DELAY(BASE_DELAY)) i_chk (
  .clk(clk), .rst(rst), .tts_mode(tts_mode), .rel_req(rel_req), .grant(grant),
  .rel_err(rel_err), .mem_req_valid(mem_req_valid), .mem_req_cmd(mem_req_cmd),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
);

// File: tb/test_lkbo_spin_acquirer.sv
module test_lkbo_spin_acquirer;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int BASE   = 4;
  localparam int SHIFT  = 1;
  localparam int MAXD   = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic tts_mode = 1'b0, acq_req = 1'b0, rel_req = 1'b0;
  logic grant, rel_err, mem_req_valid;
  logic [1:0] mem_req_cmd;
  logic mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lkbo_spin_acquirer #(.DATA_W(DATA_W), .BASE_DELAY(BASE), .GROWTH_SHIFT(SHIFT),
    .MAX_DELAY(MAXD)) i_lkbo_spin_acquirer (
    .clk(clk), .rst(rst), .tts_mode(tts_mode), .acq_req(acq_req), .rel_req(rel_req),
    .grant(grant), .rel_err(rel_err), .mem_req_valid(mem_req_valid),
    .mem_req_cmd(mem_req_cmd), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  int tests = 0, fails = 0;
  int cyc = 0;
  int lockw = 0;
  int rsp_lat = 1;
  int n_reads_plain = 0, n_tas = 0, n_rd = 0, n_err = 0, n_req = 0;
  int tas_t[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int ms = 0, md = BASE, mcnt = 0;
  bit mg = 0, mv = 0, me = 0;
  int mc = 0;
  always @(posedge clk) begin
    if (rst) begin
      ms = 0; md = BASE; mcnt = 0; mg = 0; mv = 0; me = 0; mc = 0;
    end else begin
      mv = 0;
      me = rel_req && (ms != 4);
      case (ms)
        0: if (acq_req) begin mv = 1; mc = tts_mode ? 0 : 1; ms = tts_mode ? 1 : 2; end
        1: if (mem_rsp_valid) begin
             mv = 1;
             if (mem_rsp_data == 0) begin mc = 1; ms = 2; end else mc = 0;
           end
        2: if (mem_rsp_valid) begin
             if (mem_rsp_data == 0) begin mg = 1; ms = 4; md = BASE; end
             else begin ms = 3; mcnt = md; md = (md * (1 << SHIFT) > MAXD) ? MAXD : md * (1 << SHIFT); end
           end
        3: if (mcnt == 1) begin mv = 1; mc = tts_mode ? 0 : 1; ms = tts_mode ? 1 : 2; end
           else mcnt--;
        4: if (rel_req) begin mg = 0; mv = 1; mc = 2; ms = 5; end
        5: if (mem_rsp_valid) ms = 0;
        default: ms = 0;
      endcase
    end
  end

  // Per-cycle comparison, monitors, behavioural memory, watchdog
  bit pend = 0; int pcnt = 0; int pcmd = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check(grant == mg, "R2 grant", grant, mg);
      check(mem_req_valid == mv, "R8 req_valid", mem_req_valid, mv);
      if (mv) check(mem_req_cmd == mc[1:0], "R5 cmd", mem_req_cmd, mc);
      check(rel_err == me, "R7 rel_err", rel_err, me);
      if (mem_req_valid) begin
        n_req++;
        if (mem_req_cmd == 2'd1) begin n_tas++; tas_t.push_back(cyc); end
        if (mem_req_cmd == 2'd0) begin n_rd++; if (!tts_mode) n_reads_plain++; end
      end
      if (rel_err) n_err++;
    end
    mem_rsp_valid = 1'b0;
    if (mem_req_valid) begin pend = 1; pcnt = rsp_lat; pcmd = mem_req_cmd; end
    if (pend) begin
      if (pcnt <= 1) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = DATA_W'(lockw);
        if (pcmd == 1) lockw = 1;
        if (pcmd == 2) lockw = 0;
        pend = 0;
      end else pcnt--;
    end
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_grant(input string req);
    int k = 0;
    while (!grant && k < 2000) begin step(1); k++; end
    check(grant == 1'b1, req, grant, 1);
  endtask

  task automatic release_lock();
    rel_req = 1'b1; step(1); rel_req = 1'b0; step(4);
    check(grant == 1'b0, "R6 grant low after release", grant, 0);
    check(lockw == 0, "R6 lock word cleared", lockw, 0);
  endtask

  initial begin
    int d;
    step(3);
    check(grant == 0, "R1 grant", grant, 0);
    check(mem_req_valid == 0, "R1 req", mem_req_valid, 0);
    check(rel_err == 0, "R1 err", rel_err, 0);
    rst = 1'b0; step(2);

    // Free lock, plain mode
    rsp_lat = 1; lockw = 0; acq_req = 1'b1;
    wait_grant("R2 free lock acquired");
    acq_req = 1'b0;
    check(lockw == 1, "R2 lock word set", lockw, 1);
    release_lock();

    // Contended lock, plain mode: growth and saturation
    rsp_lat = 2; lockw = 1; tas_t.delete(); acq_req = 1'b1;
    while (tas_t.size() < 7) step(1);
    lockw = 0;
    wait_grant("R2 acquire after backoff");
    acq_req = 1'b0;
    d = BASE;
    for (int i = 0; i < 6; i++) begin
      check(tas_t[i+1] - tas_t[i] == rsp_lat + d, (i == 0) ? "R3 first wait" : "R4 grown wait",
            tas_t[i+1] - tas_t[i], rsp_lat + d);
      d = (d << SHIFT > MAXD) ? MAXD : d << SHIFT;
    end
    release_lock();

    // Delay back to base after success
    lockw = 1; tas_t.delete(); acq_req = 1'b1;
    while (tas_t.size() < 2) step(1);
    lockw = 0;
    wait_grant("R9 acquire");
    acq_req = 1'b0;
    check(tas_t[1] - tas_t[0] == rsp_lat + BASE, "R9 wait reset to base",
          tas_t[1] - tas_t[0], rsp_lat + BASE);
    release_lock();
    check(n_reads_plain == 0, "R10 no reads in plain mode", n_reads_plain, 0);

    // Read spin mode
    tts_mode = 1'b1; rsp_lat = 1; lockw = 1; n_tas = 0; n_rd = 0; acq_req = 1'b1;
    step(30);
    check(n_tas == 0, "R5 no atomic during spin", n_tas, 0);
    check(n_rd >= 5, "R5 reads while held", n_rd, 5);
    lockw = 0;
    wait_grant("R5 acquire after spin");
    acq_req = 1'b0;
    check(n_tas == 1, "R5 single atomic", n_tas, 1);
    release_lock();
    tts_mode = 1'b0;

    // Release while not held
    n_req = 0; n_err = 0;
    rel_req = 1'b1; step(1); rel_req = 1'b0; step(5);
    check(n_err == 1, "R7 one error pulse", n_err, 1);
    check(n_req == 0, "R7 no memory request", n_req, 0);
    check(grant == 0, "R7 grant unchanged", grant, 0);
    check(lockw == 0, "R7 lock word untouched", lockw, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule